// File: doc/BRIEF.md
# Dual-Display Refresh Fetch Scheduler

This block decides how a shared main memory is used, cycle by cycle, when it holds the frame buffers of two raster displays. One is a colour display: 1280 pixels per line at 8 bits per pixel. The other is a monochrome display: 768 pixels per line at 1 bit per pixel. Memory cycles alternate strictly. Every second cycle is a display slot, and in each slot the scheduler issues one 256-bit refresh fetch. The cycles in between belong to a CPU or DMA requester, which receives a one-cycle grant.

A colour line needs 40 words. The monochrome display refreshes two of its lines in the time of one colour line, and each of those lines needs 3 words. That makes 46 fetches per colour line, which is exactly the number of display slots in one colour line period. A line-start strobe from the colour timing restarts a fixed slot pattern. In that pattern the six monochrome fetches fall at every seventh slot, so each monochrome line has its three words in the first or second half of the colour line. All other slots fetch colour words.

There are two word-address counters, one per display. Each counter steps by one word per fetch for its display and reloads a base address when a frame or field begins. Every fetch carries a one-bit tag that names the display its data is for.

Top module: `dual_refresh_sched`

## Requirements
- R1: After reset, `mem_valid` stays low until the first `line_start` pulse, and `cpu_gnt` stays low while `cpu_req` is low.
- R2: `mem_valid` is never high in two consecutive cycles. Within a line, successive fetches are exactly 2 cycles apart.
- R3: After a `line_start` pulse, exactly 46 fetches are issued. No further fetch follows until the next `line_start`.
- R4: Fetches in a line are numbered from 0. Fetch i carries `mem_tag` = 1 (monochrome) when i mod 7 = 6 and i/7 < 6, that is at indices 6, 13, 20, 27, 34 and 41. Every other fetch carries `mem_tag` = 0 (colour), which makes 40 colour and 6 monochrome fetches.
- R5: Each colour fetch presents the colour counter on `mem_addr`, and the counter then increases by one. The count continues across lines unless it is reloaded.
- R6: Each monochrome fetch presents the monochrome counter on `mem_addr`, and the counter then increases by one. The count continues across lines unless it is reloaded.
- R7: A `clr_field_start` pulse loads `clr_base` into the colour counter at the next clock edge. The next colour fetch then uses that base.
- R8: A `mono_frame_start` pulse loads `mono_base` into the monochrome counter at the next clock edge. The next monochrome fetch then uses that base.
- R9: `cpu_req` high in a non-display cycle is granted in that same cycle. `cpu_gnt` is never high in a display slot.
- R10: `cpu_req` seen in a display slot is held, and `cpu_gnt` rises in the following cycle even if the request has been dropped.
- R11: `cpu_gnt` never stays high for two consecutive cycles. A held request is granted only once.
- R12: A `line_start` pulse in the middle of a line restarts the pattern at index 0, so the next monochrome fetch is the seventh fetch after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle pulse at the start of each colour line |
| clr_field_start | input | 1 | One-cycle pulse at the start of a colour field; reloads the colour counter |
| clr_base | input | ADDR_W | Colour frame base, as a word address |
| mono_frame_start | input | 1 | One-cycle pulse at the start of a monochrome frame; reloads the monochrome counter |
| mono_base | input | ADDR_W | Monochrome frame base, as a word address |
| cpu_req | input | 1 | CPU or DMA memory request |
| cpu_gnt | output | 1 | One-cycle grant of a free memory cycle |
| mem_valid | output | 1 | A refresh fetch is issued in this cycle |
| mem_tag | output | 1 | Destination of the fetch: 0 colour, 1 monochrome |
| mem_addr | output | ADDR_W | Word address of the fetch |

## Verification
The fetch outputs and the grant are decoded from registered state in the same cycle, so each result has a fixed due cycle. A fetch appears in its display slot. The first fetch of a line is due in the first display slot after the clock edge that samples `line_start`. A counter reload takes effect at the edge that samples the start pulse. A grant is due in the same cycle as a request made in a free cycle, and one cycle after a request made in a display slot. The bench drives every input at the falling edge and samples 5 ns later, before the next rising edge, so each check reads the cycle in which its result is due. It places each line or mid-line restart pulse in a cycle it knows to be free, namely the cycle after an observed fetch or any cycle while the schedule is idle.

// File: rtl/dd_sched_pkg.sv
// Shared types for the dual-display refresh scheduler.
// Assumes nothing beyond a single clock domain.
package dd_sched_pkg;

    // Destination of a refresh fetch, carried on the memory command tag.
    typedef enum logic {
        TGT_COLOR = 1'b0,
        TGT_MONO  = 1'b1
    } fetch_tgt_e;

    // Number of displays served from the shared memory.
    localparam int unsigned N_DISP = 2;

endpackage

// File: rtl/refresh_slot_seq.sv
// Slot sequencer: runs the strict display/free alternation and walks
// the per-line fetch pattern. Monochrome fetches fall on every
// STRIDE-th display slot until MONO_SLOTS of them are used; all
// other slots fetch colour. Once SLOTS fetches are done, it stays
// idle until the next line start.
// Assumes line_start is a single-cycle pulse.
module refresh_slot_seq
    import dd_sched_pkg::*;
#(
    parameter int unsigned SLOTS      = 46,
    parameter int unsigned MONO_SLOTS = 6,
    parameter int unsigned STRIDE     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    output logic       disp_slot,
    output logic       fetch_now,
    output fetch_tgt_e fetch_tgt
);

    localparam int unsigned SLOT_W = $clog2(SLOTS + 1);
    localparam int unsigned STR_W  = (STRIDE > 1) ? $clog2(STRIDE) : 1;
    localparam int unsigned MC_W   = $clog2(MONO_SLOTS + 1);

    logic              phase_q;
    logic [SLOT_W-1:0] slot_cnt;
    logic [STR_W-1:0]  stride_cnt;
    logic [MC_W-1:0]   mono_cnt;
    logic              mono_pick;

    // Toggle between the free cycle and the display slot every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign disp_slot = phase_q;
    assign fetch_now = phase_q && (slot_cnt < SLOT_W'(SLOTS));
    assign mono_pick = (stride_cnt == STR_W'(STRIDE - 1))
                    && (mono_cnt < MC_W'(MONO_SLOTS));
    assign fetch_tgt = mono_pick ? TGT_MONO : TGT_COLOR;

    // Advance the line pattern on each fetch; a line start rewinds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt   <= SLOT_W'(SLOTS);
            stride_cnt <= '0;
            mono_cnt   <= '0;
        end else if (line_start) begin
            slot_cnt   <= '0;
            stride_cnt <= '0;
            mono_cnt   <= '0;
        end else if (fetch_now) begin
            slot_cnt   <= slot_cnt + SLOT_W'(1);
            stride_cnt <= (stride_cnt == STR_W'(STRIDE - 1))
                          ? '0 : stride_cnt + STR_W'(1);
            if (mono_pick) mono_cnt <= mono_cnt + MC_W'(1);
        end
    end

endmodule

// File: rtl/word_addr_ctr.sv
// Word address counter for one display's frame buffer. A load takes
// priority over a step, so a fetch in the same cycle as a reload has
// used the old address.
// Assumes load and step are qualified by the caller.
module word_addr_ctr #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] base,
    input  logic         step,
    output logic [W-1:0] addr
);

    // Reload the frame base or advance one word per fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= base;
        else if (step) addr <= addr + W'(1);
    end

endmodule

// File: rtl/cpu_slot_arb.sv
// Free-cycle arbiter. It grants a requester in any non-display cycle.
// A request seen during a display slot is remembered and granted in
// the free cycle that follows.
// Assumes free cycles and display slots alternate strictly.
module cpu_slot_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic disp_slot,
    input  logic cpu_req,
    output logic cpu_gnt
);

    logic pend_q;

    // Hold a request raised in a display slot until the next free cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (disp_slot) pend_q <= pend_q | cpu_req;
        else                pend_q <= 1'b0;
    end

    assign cpu_gnt = !disp_slot && (cpu_req || pend_q);

endmodule

// File: rtl/dual_refresh_sched.sv
// Top of the dual-display refresh fetch scheduler. It derives the slot
// pattern from the pixel geometry, keeps one address counter per
// display and tags each fetch with its destination.
// Assumes the pixel geometry divides evenly into memory words.
module dual_refresh_sched
    import dd_sched_pkg::*;
#(
    parameter int unsigned WORD_W     = 256,
    parameter int unsigned CLR_PIXELS = 1280,
    parameter int unsigned CLR_BPP    = 8,
    parameter int unsigned MONO_PIXELS = 768,
    parameter int unsigned MONO_LINES = 2,
    parameter int unsigned ADDR_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              clr_field_start,
    input  logic [ADDR_W-1:0] clr_base,
    input  logic              mono_frame_start,
    input  logic [ADDR_W-1:0] mono_base,
    input  logic              cpu_req,
    output logic              cpu_gnt,
    output logic              mem_valid,
    output logic              mem_tag,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int unsigned CLR_WORDS  = (CLR_PIXELS * CLR_BPP) / WORD_W;
    localparam int unsigned MONO_WORDS = MONO_PIXELS / WORD_W;
    localparam int unsigned MONO_SLOTS = MONO_WORDS * MONO_LINES;
    localparam int unsigned SLOTS      = CLR_WORDS + MONO_SLOTS;
    localparam int unsigned STRIDE     = SLOTS / MONO_SLOTS;

    logic       disp_slot;
    logic       fetch_now;
    fetch_tgt_e fetch_tgt;

    logic              ctr_load [N_DISP];
    logic              ctr_step [N_DISP];
    logic [ADDR_W-1:0] ctr_base [N_DISP];
    logic [ADDR_W-1:0] ctr_addr [N_DISP];

    refresh_slot_seq #(
        .SLOTS      (SLOTS),
        .MONO_SLOTS (MONO_SLOTS),
        .STRIDE     (STRIDE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .disp_slot  (disp_slot),
        .fetch_now  (fetch_now),
        .fetch_tgt  (fetch_tgt)
    );

    // Route reload strobes, bases and fetch steps to each counter.
    always_comb begin
        ctr_load[TGT_COLOR] = clr_field_start;
        ctr_base[TGT_COLOR] = clr_base;
        ctr_step[TGT_COLOR] = fetch_now && (fetch_tgt == TGT_COLOR);
        ctr_load[TGT_MONO]  = mono_frame_start;
        ctr_base[TGT_MONO]  = mono_base;
        ctr_step[TGT_MONO]  = fetch_now && (fetch_tgt == TGT_MONO);
    end

    for (genvar d = 0; d < N_DISP; d++) begin : g_ctr
        word_addr_ctr #(.W(ADDR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ctr_load[d]),
            .base  (ctr_base[d]),
            .step  (ctr_step[d]),
            .addr  (ctr_addr[d])
        );
    end

    cpu_slot_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_slot (disp_slot),
        .cpu_req   (cpu_req),
        .cpu_gnt   (cpu_gnt)
    );

    // Present the selected display's counter on the command port.
    always_comb begin
        mem_valid = fetch_now;
        mem_tag   = fetch_tgt;
        mem_addr  = (fetch_tgt == TGT_MONO) ? ctr_addr[TGT_MONO]
                                            : ctr_addr[TGT_COLOR];
    end

endmodule

// File: rtl/dual_refresh_sched_chk.sv
// Protocol checker for the refresh scheduler ports, bound to the top.
module dual_refresh_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_gnt,
    input logic mem_valid
);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_valid);

    // R2
    no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> !mem_valid);

    // R9
    gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && mem_valid));

    // R10
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && mem_valid) |=> cpu_gnt);

    // R11
    gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |=> !cpu_gnt);

endmodule

bind dual_refresh_sched dual_refresh_sched_chk u_chk (.*);

// File: tb/sim_dual_refresh_sched.sv
// Directed bench for the refresh scheduler: one task per scenario.
module sim_dual_refresh_sched;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_start = 1'b0;
    logic          clr_field_start = 1'b0;
    logic [AW-1:0] clr_base = '0;
    logic          mono_frame_start = 1'b0;
    logic [AW-1:0] mono_base = '0;
    logic          cpu_req = 1'b0;
    logic          cpu_gnt;
    logic          mem_valid;
    logic          mem_tag;
    logic [AW-1:0] mem_addr;

    always #10 clk = ~clk;

    dual_refresh_sched #(.ADDR_W(AW)) u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [AW-1:0] exp_c = '0;
    logic [AW-1:0] exp_m = '0;
    int fidx = 46;
    int last_cyc = 0;
    bit last_tag = 0;
    string lbl_c = "R5";
    string lbl_m = "R6";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit mono_at(int i);
        return (i % 7 == 6) && (i / 7 < 6);
    endfunction

    // Check a fetch seen in the current cycle against the line model.
    task automatic eval_fetch();
        bit m;
        if (mem_valid) begin
            m = mono_at(fidx);
            check(fidx < 46, "R3", "fetch index inside line", fidx, 45);
            check(mem_tag == m, "R4", "fetch tag", mem_tag, m);
            if (m) begin
                check(mem_addr == exp_m, lbl_m, "mono address", mem_addr, exp_m);
                exp_m++;
                lbl_m = "R6";
            end else begin
                check(mem_addr == exp_c, lbl_c, "colour address", mem_addr, exp_c);
                exp_c++;
                lbl_c = "R5";
            end
            if (fidx > 0)
                check(cyc - last_cyc == 2, "R2", "fetch spacing", cyc - last_cyc, 2);
            last_cyc = cyc;
            last_tag = mem_tag;
            fidx++;
        end
    endtask

    task automatic step(bit req);
        @(negedge clk);
        cpu_req = req;
        #5;
        eval_fetch();
    endtask

    // Pulse a line start (and optional reloads) in a free or idle cycle.
    task automatic start_line(bit rc, bit rm);
        @(negedge clk);
        line_start = 1'b1;
        clr_field_start = rc;
        mono_frame_start = rm;
        if (rc) begin exp_c = clr_base;  lbl_c = "R7"; end
        if (rm) begin exp_m = mono_base; lbl_m = "R8"; end
        fidx = 0;
        @(posedge clk);
        #1;
        line_start = 1'b0;
        clr_field_start = 1'b0;
        mono_frame_start = 1'b0;
    endtask

    task automatic finish_line();
        int extra;
        for (int i = 0; i < 200 && fidx < 46; i++) step(1'b0);
        check(fidx == 46, "R3", "fetches in line", fidx, 46);
        extra = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b0);
            if (mem_valid) extra++;
        end
        check(extra == 0, "R3", "fetches after line end", extra, 0);
    endtask

    task automatic t_reset();
        int bad_v, bad_g;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bad_v = 0;
        bad_g = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #5;
            if (mem_valid) bad_v++;
            if (cpu_gnt) bad_g++;
        end
        check(bad_v == 0, "R1", "fetches before first line", bad_v, 0);
        check(bad_g == 0, "R1", "grants without request", bad_g, 0);
    endtask

    task automatic t_first_line();
        clr_base = 20'h01000;
        mono_base = 20'h80000;
        start_line(1'b1, 1'b1);
        finish_line();
    endtask

    task automatic t_next_line();
        start_line(1'b0, 1'b0);
        finish_line();
        check(exp_c == 20'h01050, "R5", "colour count after two lines", exp_c, 20'h01050);
        check(exp_m == 20'h8000c, "R6", "mono count after two lines", exp_m, 20'h8000c);
    endtask

    task automatic t_colour_reload();
        clr_base = 20'h04400;
        start_line(1'b1, 1'b0);
        finish_line();
    endtask

    task automatic t_mono_reload();
        mono_base = 20'h90010;
        start_line(1'b0, 1'b1);
        finish_line();
    endtask

    task automatic t_restart();
        start_line(1'b0, 1'b0);
        for (int i = 0; i < 100 && fidx < 10; i++) step(1'b0);
        start_line(1'b0, 1'b0);
        for (int i = 0; i < 100 && fidx < 7; i++) step(1'b0);
        check(last_tag == 1'b1, "R12", "seventh fetch after restart is mono", last_tag, 1);
        finish_line();
    endtask

    task automatic t_cpu();
        start_line(1'b0, 1'b0);
        for (int i = 0; i < 100 && fidx < 1; i++) step(1'b0);
        step(1'b1);
        check(cpu_gnt == 1'b1, "R9", "grant in free cycle", cpu_gnt, 1);
        step(1'b1);
        check(mem_valid == 1'b1, "R2", "display slot follows free", mem_valid, 1);
        check(cpu_gnt == 1'b0, "R9", "no grant in display slot", cpu_gnt, 0);
        step(1'b0);
        check(cpu_gnt == 1'b1, "R10", "held request granted", cpu_gnt, 1);
        step(1'b0);
        check(cpu_gnt == 1'b0, "R11", "grant dropped in display slot", cpu_gnt, 0);
        step(1'b0);
        check(cpu_gnt == 1'b0, "R11", "held request granted once", cpu_gnt, 0);
        finish_line();
    endtask

    initial begin
        t_reset();
        t_first_line();
        t_next_line();
        t_colour_reload();
        t_mono_reload();
        t_restart();
        t_cpu();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule